// File: doc/BRIEF.md
# Multi-Source Interrupt Vector Router

The router samples seven level-sensitive interrupt inputs into status bits. It steers each asserted input onto one of six source lines that feed a downstream interrupt controller. Six vector registers control the steering. Each holds a server number, a priority and a source selector. The first two inputs share vector 0, so they also share that vector's line. The other five inputs each own one vector (input k uses vector k-1).

A priority of all ones masks a vector. Masking does not gate the source line, because the controller applies it through the priority exposed for that source. A per-vector pending flag shows the asserted-and-unmasked state. This flag is re-evaluated only when one of the vector's inputs changes. A write that masks the vector clears it.

Software writes through an index/data strobe:
- Indices 0 to 5 select the vector registers.
- Index 6 selects a base register. Each source number is added to this base to form the global interrupt number presented with that source.

The block exposes the routed server and priority for each source.

Top module: `irq_vec_router`

## Requirements
- R1: After reset, vector i has server 0, priority 0xFF and source selector i. All pending flags, status bits, source lines and the base are zero.
- R2: Writing index 0..5 with a valid selector loads three fields of the 64-bit data into that vector: server from bits 55:40, priority from bits 39:32 and source selector from bits 31:29. All other bits are ignored. The routed server on `srv_o` is the server field shifted right by 2.
- R3: One cycle after `irq_i` changes, the status bits follow it. `ctl_stat_o[1]` follows `irq_i[0]` and `ctl_stat_o[0]` follows `irq_i[1]`. `ext_stat_o[4]` down to `ext_stat_o[0]` follow `irq_i[2]` up to `irq_i[6]`.
- R4: One cycle after an input rises, `src_line_o[s]` goes high, where s is the selector of that input's vector. This happens whether or not the vector is masked. The line falls one cycle after every vector selecting s is deasserted.
- R5: Vector 0 is asserted while either `irq_i[0]` or `irq_i[1]` is high, so its line stays high until both are low.
- R6: When any input of a vector changes, that vector's pending flag becomes (asserted AND priority != 0xFF), visible one cycle later. Otherwise the flag holds.
- R7: A valid vector write with priority 0xFF clears the pending flag. Any other valid write leaves the flag unchanged, and unmasking does not set it.
- R8: A vector write whose selector is 6 or 7 changes nothing. `wr_err_o` is high for the one cycle after such a write and low otherwise.
- R9: Writing index 6 loads a 19-bit base from data bits 63:45. `gnum_o` slice s equals (base + s) modulo 2^19.
- R10: For source s, `srv_o` and `prio_o` come from the lowest-numbered vector whose selector is s. If no vector selects s, they are 0 and 0xFF. `src_line_o[s]` is the OR over all vectors that select s.
- R11: A write to index 7 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 7 | Level interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Register index (0..5 vectors, 6 base) |
| wr_data_i | input | 64 | Write data |
| src_line_o | output | 6 | One interrupt line per source number |
| pend_o | output | 6 | Pending flag per vector |
| ctl_stat_o | output | 2 | Status of the two shared inputs |
| ext_stat_o | output | 5 | Status of the five single inputs |
| srv_o | output | 84 | Routed server per source, 14 bits each |
| prio_o | output | 48 | Priority per source, 8 bits each |
| gnum_o | output | 114 | Global interrupt number per source, 19 bits each |
| wr_err_o | output | 1 | Invalid selector write flag |

## Verification
The bench builds the block with its default of six vectors and seven inputs. At that size every one of the 128 input level combinations can be driven, and each vector can be written with all eight selector codes. This covers the invalid selector codes and the cases where several vectors collapse onto one source. A model of the registers predicts every output after each step. Directed sequences cover the pending corners: a mask write clears the flag, and unmasking leaves it clear until a shared input toggles.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;
  parameter int unsigned DATA_W   = 64;
  parameter int unsigned SRV_W    = 16;
  parameter int unsigned PRIO_W   = 8;
  parameter int unsigned SEL_W    = 3;
  parameter int unsigned BASE_W   = 19;
  parameter int unsigned LINK_W   = 2;
  parameter int unsigned SRV_LSB  = 40;
  parameter int unsigned PRIO_LSB = 32;
  parameter int unsigned SEL_LSB  = 29;
  parameter int unsigned BASE_LSB = 45;
  parameter int unsigned RSRV_W   = SRV_W - LINK_W;

  typedef struct packed {
    logic [SRV_W-1:0]  srv;
    logic [PRIO_W-1:0] prio;
    logic [SEL_W-1:0]  sel;
  } vec_cfg_t;

  function automatic vec_cfg_t unpack_vec(logic [DATA_W-1:0] d);
    vec_cfg_t c;
    c.srv  = d[SRV_LSB  +: SRV_W];
    c.prio = d[PRIO_LSB +: PRIO_W];
    c.sel  = d[SEL_LSB  +: SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/irq_rtr_vec.sv
module irq_rtr_vec
  import irq_rtr_pkg::*;
#(
  parameter int unsigned NUM_VEC = 6,
  parameter int unsigned IDX     = 0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  vec_cfg_t wcfg_i,
  input  logic     chg_i,
  input  logic     asrt_i,
  input  logic     asrt_nx_i,
  output vec_cfg_t cfg_o,
  output logic     pend_o,
  output logic     bad_o
);
  localparam logic [SEL_W:0]    SEL_LIM = (SEL_W+1)'(NUM_VEC);
  localparam logic [PRIO_W-1:0] PRIO_MSK = '1;

  vec_cfg_t cfg_q, cfg_nx;
  logic     pend_q, upd;

  assign bad_o  = wr_i && ({1'b0, wcfg_i.sel} >= SEL_LIM);
  assign upd    = wr_i && !bad_o;
  assign cfg_nx = upd ? wcfg_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.srv  <= '0;
      cfg_q.prio <= PRIO_MSK;
      cfg_q.sel  <= SEL_W'(IDX);
    end else begin
      cfg_q <= cfg_nx;
    end
  end

  // pending follows level on input change; a masking write clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              pend_q <= 1'b0;
    else if (chg_i)                           pend_q <= asrt_nx_i && (cfg_nx.prio != PRIO_MSK);
    else if (upd && wcfg_i.prio == PRIO_MSK)  pend_q <= 1'b0;
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_q;

  AST_PEND_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (cfg_q.prio != PRIO_MSK)); // R6
  AST_PEND_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> asrt_i); // R6
  AST_BAD_SEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> $stable(cfg_q)); // R8
  AST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cfg_q.sel} < SEL_LIM); // R8
endmodule

// File: rtl/irq_rtr_route.sv
module irq_rtr_route
  import irq_rtr_pkg::*;
#(
  parameter int unsigned NUM_VEC = 6
) (
  input  vec_cfg_t                    cfg_i [NUM_VEC],
  input  logic [NUM_VEC-1:0]          asrt_i,
  input  logic [BASE_W-1:0]           base_i,
  output logic [NUM_VEC-1:0]          line_o,
  output logic [NUM_VEC*RSRV_W-1:0]   srv_o,
  output logic [NUM_VEC*PRIO_W-1:0]   prio_o,
  output logic [NUM_VEC*BASE_W-1:0]   gnum_o
);
  logic [RSRV_W-1:0] srv_a  [NUM_VEC];
  logic [PRIO_W-1:0] prio_a [NUM_VEC];

  // descending scan: lowest vector index wins the server/priority
  always_comb begin
    for (int s = 0; s < NUM_VEC; s++) begin
      line_o[s] = 1'b0;
      srv_a[s]  = '0;
      prio_a[s] = '1;
      for (int v = NUM_VEC-1; v >= 0; v--) begin
        if (cfg_i[v].sel == SEL_W'(s)) begin
          line_o[s] = line_o[s] | asrt_i[v];
          srv_a[s]  = cfg_i[v].srv[SRV_W-1:LINK_W];
          prio_a[s] = cfg_i[v].prio;
        end
      end
    end
  end

  for (genvar s = 0; s < NUM_VEC; s++) begin : g_src
    assign srv_o [s*RSRV_W +: RSRV_W] = srv_a[s];
    assign prio_o[s*PRIO_W +: PRIO_W] = prio_a[s];
    assign gnum_o[s*BASE_W +: BASE_W] = base_i + BASE_W'(s);
  end
endmodule

// File: rtl/irq_vec_router.sv
module irq_vec_router
  import irq_rtr_pkg::*;
#(
  parameter int unsigned NUM_VEC = 6,
  parameter int unsigned IDX_W   = 3,
  localparam int unsigned NUM_IN = NUM_VEC + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_IN-1:0]             irq_i,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [NUM_VEC-1:0]            src_line_o,
  output logic [NUM_VEC-1:0]            pend_o,
  output logic [1:0]                    ctl_stat_o,
  output logic [NUM_VEC-2:0]            ext_stat_o,
  output logic [NUM_VEC*RSRV_W-1:0]     srv_o,
  output logic [NUM_VEC*PRIO_W-1:0]     prio_o,
  output logic [NUM_VEC*BASE_W-1:0]     gnum_o,
  output logic                          wr_err_o
);
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(NUM_VEC);

  logic [NUM_IN-1:0]  stat_q;
  logic [NUM_VEC-1:0] asrt, asrt_nx, chg, vwr, bad;
  logic [BASE_W-1:0]  base_q;
  logic               err_q;
  vec_cfg_t           wcfg;
  vec_cfg_t           cfg [NUM_VEC];

  assign wcfg = unpack_vec(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      stat_q <= irq_i;
      err_q  <= |bad;
      if (wr_en_i && wr_idx_i == BASE_IDX) base_q <= wr_data_i[BASE_LSB +: BASE_W];
    end
  end

  // vector 0 is shared by inputs 0 and 1
  assign asrt[0]    = stat_q[0] | stat_q[1];
  assign asrt_nx[0] = irq_i[0] | irq_i[1];
  assign chg[0]     = irq_i[1:0] != stat_q[1:0];

  for (genvar v = 1; v < NUM_VEC; v++) begin : g_single
    assign asrt[v]    = stat_q[v+1];
    assign asrt_nx[v] = irq_i[v+1];
    assign chg[v]     = irq_i[v+1] != stat_q[v+1];
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign vwr[v] = wr_en_i && (wr_idx_i == IDX_W'(v));
    irq_rtr_vec #(.NUM_VEC(NUM_VEC), .IDX(v)) u_vec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (vwr[v]),
      .wcfg_i    (wcfg),
      .chg_i     (chg[v]),
      .asrt_i    (asrt[v]),
      .asrt_nx_i (asrt_nx[v]),
      .cfg_o     (cfg[v]),
      .pend_o    (pend_o[v]),
      .bad_o     (bad[v])
    );
    AST_LINE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      asrt[v] |-> src_line_o[cfg[v].sel]); // R4
  end

  irq_rtr_route #(.NUM_VEC(NUM_VEC)) u_route (
    .cfg_i  (cfg),
    .asrt_i (asrt),
    .base_i (base_q),
    .line_o (src_line_o),
    .srv_o  (srv_o),
    .prio_o (prio_o),
    .gnum_o (gnum_o)
  );

  assign ctl_stat_o = {stat_q[0], stat_q[1]};
  for (genvar k = 0; k < NUM_VEC-1; k++) begin : g_ext
    assign ext_stat_o[k] = stat_q[NUM_VEC-k];
  end
  assign wr_err_o = err_q;

  AST_SHARED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_stat_o != 2'b00) |-> src_line_o[cfg[0].sel]); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i && wr_idx_i < BASE_IDX)); // R8
  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == BASE_IDX) |=> $stable(base_q)); // R9
endmodule

// File: tb/irq_vec_router_bench.sv
module irq_vec_router_bench;
  localparam int NV = 6;
  localparam int NI = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NI-1:0]   irq = '0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_idx = '0;
  logic [63:0]     wr_data = '0;
  logic [NV-1:0]   line, pend;
  logic [1:0]      ctl;
  logic [NV-2:0]   ext;
  logic [NV*14-1:0] srv;
  logic [NV*8-1:0]  prio;
  logic [NV*19-1:0] gnum;
  logic            err;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_srv  [NV];
  logic [7:0]  m_prio [NV];
  logic [2:0]  m_sel  [NV];
  logic        m_pend [NV];
  logic [NI-1:0] m_stat;
  logic [18:0] m_base;
  logic        m_err;

  always #5ns clk = ~clk;

  irq_vec_router u_irq_vec_router (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .src_line_o(line), .pend_o(pend), .ctl_stat_o(ctl),
    .ext_stat_o(ext), .srv_o(srv), .prio_o(prio), .gnum_o(gnum), .wr_err_o(err)
  );

  task automatic chk(string ctx, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", ctx, req, act, exp);
    end
  endtask

  function automatic logic m_asrt(int v, logic [NI-1:0] st);
    return (v == 0) ? (st[0] | st[1]) : st[v+1];
  endfunction

  task automatic check_all(string ctx);
    logic [NV-1:0] e_line, e_pend;
    logic [NV-2:0] e_ext;
    for (int s = 0; s < NV; s++) begin
      logic [13:0] es = '0;
      logic [7:0]  ep = 8'hFF;
      e_line[s] = 1'b0;
      for (int v = NV-1; v >= 0; v--) begin
        if (m_sel[v] == 3'(s)) begin
          e_line[s] |= m_asrt(v, m_stat);
          es = m_srv[v][15:2];
          ep = m_prio[v];
        end
      end
      chg_srv: chk(ctx, "R2 R10 srv", 64'(srv[s*14 +: 14]), 64'(es));
      chk(ctx, "R10 prio", 64'(prio[s*8 +: 8]), 64'(ep));
      chk(ctx, "R9 gnum", 64'(gnum[s*19 +: 19]), 64'(19'(m_base + 19'(s))));
    end
    for (int v = 0; v < NV; v++) e_pend[v] = m_pend[v];
    for (int k = 0; k < NV-1; k++) e_ext[k] = m_stat[NV-k];
    chk(ctx, "R4 line", 64'(line), 64'(e_line));
    chk(ctx, "R6 pend", 64'(pend), 64'(e_pend));
    chk(ctx, "R3 ctl", 64'(ctl), 64'({m_stat[0], m_stat[1]}));
    chk(ctx, "R3 ext", 64'(ext), 64'(e_ext));
    chk(ctx, "R8 err", 64'(err), 64'(m_err));
  endtask

  task automatic set_irq(logic [NI-1:0] val, string ctx);
    logic [NI-1:0] old;
    @(negedge clk);
    irq = val;
    @(negedge clk);
    old = m_stat;
    for (int v = 0; v < NV; v++) begin
      logic c = (v == 0) ? (val[1:0] != old[1:0]) : (val[v+1] != old[v+1]);
      if (c) m_pend[v] = m_asrt(v, val) && (m_prio[v] != 8'hFF);
    end
    m_stat = val;
    m_err = 1'b0;
    check_all(ctx);
  endtask

  task automatic do_write(logic [2:0] idx, logic [63:0] d, string ctx);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_err = 1'b0;
    if (idx < 3'(NV)) begin
      if (d[31:29] >= 3'(NV)) m_err = 1'b1;
      else begin
        m_srv[idx] = d[55:40]; m_prio[idx] = d[39:32]; m_sel[idx] = d[31:29];
        if (d[39:32] == 8'hFF) m_pend[idx] = 1'b0;
      end
    end else if (idx == 3'(NV)) begin
      m_base = d[63:45];
    end
    check_all(ctx);
  endtask

  task automatic idle(string ctx);
    @(negedge clk);
    m_err = 1'b0;
    check_all(ctx);
  endtask

  function automatic logic [63:0] vec_word(logic [15:0] s, logic [7:0] p, logic [2:0] sel);
    // junk in unused bits exercises R2 field isolation
    return 64'hA5000000_1EFFFFFF | ({8'h0, s, 40'h0}) | ({24'h0, p, 32'h0}) | ({32'h0, sel, 29'h0});
  endfunction

  function automatic logic [63:0] clean_word(logic [15:0] s, logic [7:0] p, logic [2:0] sel);
    return (64'(s) << 40) | (64'(p) << 32) | (64'(sel) << 29);
  endfunction

  initial begin
    #2ms;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      m_srv[v] = '0; m_prio[v] = 8'hFF; m_sel[v] = 3'(v); m_pend[v] = 1'b0;
    end
    m_stat = '0; m_base = '0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    // single inputs while masked: lines rise, pending stays low
    for (int i = 0; i < NI; i++) begin
      set_irq(NI'(1) << i, "R3 R4 single masked");
      set_irq('0, "R4 fall");
    end

    // unmask with distinct fields; unused data bits set (R2)
    for (int v = 0; v < NV; v++) begin
      logic [63:0] w = vec_word(16'h1003 + 16'(v * 291), 8'(v * 16 + 1), 3'(v));
      w[63:56] = 8'hA5; // keep junk outside fields
      do_write(3'(v), (w & ~64'h00FFFFFF_E0000000) | clean_word(16'h1003 + 16'(v * 291), 8'(v * 16 + 1), 3'(v)), "R2 unmask write");
    end

    // all input levels
    for (int p = 0; p < (1 << NI); p++) set_irq(NI'(p), "R6 level sweep");
    set_irq('0, "R6 clear");

    // shared vector hold
    set_irq(7'b0000011, "R5 both shared");
    set_irq(7'b0000010, "R5 one shared left");
    set_irq(7'b0000001, "R5 swap shared");
    set_irq(7'b0000000, "R5 shared drop");

    // pending vs writes on vector 1 (input 2)
    set_irq(7'b0000100, "R6 v1 pend");
    do_write(3'd1, clean_word(16'h0040, 8'h22, 3'd1), "R7 keep pend");
    do_write(3'd1, clean_word(16'h0040, 8'hFF, 3'd1), "R7 mask clears");
    do_write(3'd1, clean_word(16'h0040, 8'h10, 3'd1), "R7 unmask no set");
    set_irq('0, "R6 v1 fall");

    // shared vector re-evaluation after unmask
    set_irq(7'b0000001, "R6 shared pend");
    do_write(3'd0, clean_word(16'h0104, 8'hFF, 3'd0), "R7 shared mask");
    do_write(3'd0, clean_word(16'h0104, 8'h05, 3'd0), "R7 shared unmask");
    set_irq(7'b0000011, "R6 shared reeval");
    set_irq('0, "R6 shared off");

    // selector sweep incl. invalid codes
    set_irq(7'b1010101, "R10 hold inputs");
    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] pr = ((v + s) % 3 == 0) ? 8'hFF : 8'(s * 9 + v);
        do_write(3'(v), clean_word(16'(v * 4099 + s * 17), pr, 3'(s)), "R8 R10 sel sweep");
        idle("R8 err clears");
      end
    end
    for (int p = 0; p < (1 << NI); p += 9) set_irq(NI'(p), "R10 collapsed lines");
    set_irq(7'b1111111, "R10 all on");

    // base register
    do_write(3'd6, {19'h5A5A5, 45'h1FFF_FFFF_FFFF}, "R9 base");
    do_write(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, "R9 base wrap");
    do_write(3'd6, {19'h00012, 45'h0}, "R9 base small");

    // index 7 ignored
    do_write(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, "R11 idx7 ignored");
    do_write(3'd7, 64'h0, "R11 idx7 zero");
    idle("R11 after");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule